// File: doc/BRIEF.md
# Sliding-Window Antipodal Correlation Matrix Updater

This block maintains a running correlation matrix over a sliding window of antipodal (±1) bit vectors, the kind of training or tracking symbols a multiuser receiver uses to estimate its channels. Each bit-period the block can accept two vectors of width 2K. One is the vector entering the window and the other is the vector leaving it. Every matrix entry (j,k) gains the product of the two incoming bits and loses the product of the two outgoing bits. A bit is held as a single binary digit, so each ±1 product reduces to an XNOR of two bits. Each entry is then a saturating up/down counter that moves by at most two per update.

The matrix is symmetric, and its diagonal is always the window length. Counters therefore exist only for the K(2K−1) entries strictly above the diagonal. A read of an entry below the diagonal is served from its mirror above it, and a diagonal read returns the window length as a constant. After a clear, the first window-length updates fill the window: the outgoing vector is ignored during that time, so only additions take place. Reads are registered and return one cycle after the request.

Top module: `corr_window_updater`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, every off-diagonal entry reads 0. When `clr` and `upd_valid` are high together, the clear wins and the update is dropped.
- R2: Bit value 1 encodes +1 and 0 encodes −1. During the fill, an accepted update changes entry (j,k) by +1 when `new_bits[j]` equals `new_bits[k]` and by −1 otherwise.
- R3: Once the window is full, an accepted update changes entry (j,k) by the product of the incoming bit pair minus the product of the outgoing bit pair. The change is therefore −2, 0 or +2, and it is 0 whenever the two products agree.
- R4: During the first WIN_LEN accepted updates after reset or clear, `old_bits` has no effect. From the next update on, it takes part.
- R5: Entries are 8-bit two's complement values. They saturate at +127 and −128 and never wrap.
- R6: A read of a diagonal entry (row equal to column) returns WIN_LEN at all times.
- R7: A read at (row,col) with row greater than col returns the same value as a read at (col,row).
- R8: `rd_valid` is high exactly in the cycle after `rd_req`. `rd_data` then holds the entry as it was before any update accepted in the request cycle.
- R9: While `upd_valid` and `clr` are both low, no entry changes, whatever `new_bits` and `old_bits` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of all entries and of the fill state |
| upd_valid | input | 1 | Accept one window update this cycle |
| new_bits | input | 2K (8) | Vector entering the window, bit i is element i |
| old_bits | input | 2K (8) | Vector leaving the window |
| rd_req | input | 1 | Read request |
| rd_row | input | log2(2K) (3) | Row index of the read |
| rd_col | input | log2(2K) (3) | Column index of the read |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 8 | Signed entry value |

## Verification
A bad counter step or a mis-wired bit pair shows up as a wrong value at the next read of that entry, one cycle after the request. The bench reads a different entry every cycle and sweeps the whole matrix, so every cell is observed within 64 cycles. A fill tracker that opens the window too early or too late moves every entry by ±1 on the affected update. That error is visible at once and persists, so the first read of any entry after the fill boundary exposes it. Faulty saturation or wrap-around appears as a jump of about 256 in an entry held at its limit, and an error in the mirrored index appears as a mismatch on reads below the diagonal.

// File: rtl/corr_win_pkg.sv
package corr_win_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_DIAG  = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_LOWER = 2'd3
  } rd_sel_e;

  // Linear slot of entry (r,c), r < c, in an upper-triangle packing of an n x n matrix
  function automatic int pair_index(input int r, input int c, input int n);
    return r * n - (r * (r + 1)) / 2 + (c - r - 1);
  endfunction

  // Net change of one entry: +-1 from the incoming pair, minus +-1 from the outgoing pair
  function automatic logic signed [2:0] pair_step(input logic na, input logic nb,
                                                  input logic oa, input logic ob,
                                                  input logic old_en);
    logic signed [2:0] up_part;
    logic signed [2:0] dn_part;
    up_part = (na ~^ nb) ? 3'sb001 : 3'sb111;
    if (!old_en)
      dn_part = 3'sb000;
    else
      dn_part = (oa ~^ ob) ? 3'sb001 : 3'sb111;
    return up_part - dn_part;
  endfunction

  // Which part of the matrix a read address falls in
  function automatic rd_sel_e classify(input int r, input int c, input int n);
    if (r >= n || c >= n) return SEL_NONE;
    if (r == c)           return SEL_DIAG;
    if (r < c)            return SEL_UPPER;
    return SEL_LOWER;
  endfunction

endpackage

// File: rtl/corr_pair_cell.sv
module corr_pair_cell
  import corr_win_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             new_a,
  input  logic             new_b,
  input  logic             old_a,
  input  logic             old_b,
  input  logic             old_en,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};

  logic signed [2:0] step;
  logic [CNT_W:0]    sum_ext;
  logic              ovf;
  logic [CNT_W-1:0]  next_v;
  logic              prod_agree;

  assign step       = pair_step(new_a, new_b, old_a, old_b, old_en);
  assign sum_ext    = {count[CNT_W-1], count} + {{(CNT_W-2){step[2]}}, step};
  assign ovf        = sum_ext[CNT_W] ^ sum_ext[CNT_W-1];
  assign next_v     = ovf ? (sum_ext[CNT_W] ? MIN_V : MAX_V) : sum_ext[CNT_W-1:0];
  assign prod_agree = ((new_a ~^ new_b) == (old_a ~^ old_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (upd)  count <= next_v;
  end

  // R9: idle cycles leave the entry untouched
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(count));
  // R1: clear empties the entry
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R5: no wrap at the positive limit
  p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && count == MAX_V && !step[2]) |=> (count == MAX_V));
  // R5: no wrap at the negative limit
  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && count == MIN_V && step[2]) |=> (count == MIN_V));
  // R3: equal incoming and outgoing products cancel
  p_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && old_en && prod_agree) |=> $stable(count));

endmodule

// File: rtl/corr_fill_tracker.sv
module corr_fill_tracker #(
  parameter int WIN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  output logic old_en
);
  localparam int FW = $clog2(WIN_LEN + 1);
  localparam logic [FW-1:0] FULL_V = FW'(WIN_LEN);

  logic [FW-1:0] fill_cnt;
  logic          fill_step;

  assign fill_step = upd && (fill_cnt != FULL_V);
  assign old_en    = (fill_cnt == FULL_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fill_cnt <= '0;
    else if (clr)       fill_cnt <= '0;
    else if (fill_step) fill_cnt <= fill_cnt + 1'b1;
  end

  // R4: the fill count never passes the window length
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= FULL_V);
  // R4: a clear reopens the fill phase
  p_fill_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !old_en);
  // R4: once full, the window stays full until cleared
  p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (old_en && !clr) |=> old_en);

endmodule

// File: rtl/corr_read_port.sv
module corr_read_port
  import corr_win_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int CNT_W     = 8,
  parameter int WIN_LEN   = 8,
  parameter int IDX_W     = 3,
  parameter int NUM_PAIRS = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pair_vals [NUM_PAIRS],
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_row,
  input  logic [IDX_W-1:0] rd_col,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  localparam int PW = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam int MAX_I = 2 ** (CNT_W - 1) - 1;
  localparam logic [CNT_W-1:0] DIAG_V = (WIN_LEN > MAX_I) ? CNT_W'(MAX_I) : CNT_W'(WIN_LEN);

  rd_sel_e          sel;
  logic [PW-1:0]    slot;
  logic [CNT_W-1:0] pick;

  always_comb begin
    sel  = classify(int'(rd_row), int'(rd_col), VEC_W);
    slot = '0;
    pick = '0;
    case (sel)
      SEL_DIAG:  pick = DIAG_V;
      SEL_UPPER: begin
        slot = PW'(pair_index(int'(rd_row), int'(rd_col), VEC_W));
        pick = pair_vals[slot];
      end
      SEL_LOWER: begin
        slot = PW'(pair_index(int'(rd_col), int'(rd_row), VEC_W));
        pick = pair_vals[slot];
      end
      default:   pick = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= pick;
    end
  end

  // R8: one-cycle read latency
  p_rd_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R8: no spurious valid
  p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R6: diagonal reads return the window length
  p_diag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && sel == SEL_DIAG) |=> (rd_data == DIAG_V));

endmodule

// File: rtl/corr_window_updater.sv
module corr_window_updater
  import corr_win_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int CNT_W     = 8,
  parameter int WIN_LEN   = 8,
  localparam int VEC_W     = 2 * NUM_USERS,
  localparam int NUM_PAIRS = NUM_USERS * (VEC_W - 1),
  localparam int IDX_W     = $clog2(VEC_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    upd_valid,
  input  logic [VEC_W-1:0]        new_bits,
  input  logic [VEC_W-1:0]        old_bits,
  input  logic                    rd_req,
  input  logic [IDX_W-1:0]        rd_row,
  input  logic [IDX_W-1:0]        rd_col,
  output logic                    rd_valid,
  output logic signed [CNT_W-1:0] rd_data
);
  logic             upd_fire;
  logic             old_en;
  logic [CNT_W-1:0] pair_vals [NUM_PAIRS];
  logic [CNT_W-1:0] rd_raw;

  assign upd_fire = upd_valid && !clr;

  corr_fill_tracker #(.WIN_LEN(WIN_LEN)) u_fill (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .upd    (upd_fire),
    .old_en (old_en)
  );

  for (genvar j = 0; j < VEC_W; j++) begin : g_row
    for (genvar k = j + 1; k < VEC_W; k++) begin : g_col
      localparam int SLOT = pair_index(j, k, VEC_W);
      corr_pair_cell #(.CNT_W(CNT_W)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .upd    (upd_fire),
        .new_a  (new_bits[j]),
        .new_b  (new_bits[k]),
        .old_a  (old_bits[j]),
        .old_b  (old_bits[k]),
        .old_en (old_en),
        .count  (pair_vals[SLOT])
      );
    end
  end

  corr_read_port #(
    .VEC_W     (VEC_W),
    .CNT_W     (CNT_W),
    .WIN_LEN   (WIN_LEN),
    .IDX_W     (IDX_W),
    .NUM_PAIRS (NUM_PAIRS)
  ) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_vals (pair_vals),
    .rd_req    (rd_req),
    .rd_row    (rd_row),
    .rd_col    (rd_col),
    .rd_valid  (rd_valid),
    .rd_data   (rd_raw)
  );

  assign rd_data = rd_raw;

  // R1: clear takes priority over a simultaneous update
  p_clr_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && upd_valid) |-> !upd_fire);
  // R4: fill state restarts after a clear
  p_fill_reopen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !old_en);

endmodule

// File: tb/corr_window_updater_tb_top.sv
module corr_window_updater_tb_top;
  localparam int VW = 8;
  localparam int L  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, upd_valid = 1'b0, rd_req = 1'b0;
  logic [VW-1:0] new_bits = '0, old_bits = '0;
  logic [2:0] rd_row = '0, rd_col = '0;
  logic rd_valid;
  logic signed [7:0] rd_data;

  always #2.5 clk = ~clk;

  corr_window_updater #(.NUM_USERS(4), .CNT_W(8), .WIN_LEN(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd_valid(upd_valid),
    .new_bits(new_bits), .old_bits(old_bits), .rd_req(rd_req),
    .rd_row(rd_row), .rd_col(rd_col), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_tests = 0, n_fail = 0;
  int refm [VW][VW];
  int fills = 0;
  int rd_ptr = 0;
  bit exp_v = 0;
  int exp_d = 0;
  string exp_tag = "R1";
  string phase = "R1";
  int unsigned seed = 32'h1234_5678;
  logic [VW-1:0] hist [$];

  function automatic logic [7:0] rnd8();
    seed = seed * 1664525 + 1013904223;
    return seed[23:16];
  endfunction

  function automatic int ref_read(int r, int c);
    if (r == c) return L;
    if (r < c) return refm[r][c];
    return refm[c][r];
  endfunction

  function automatic string tag_for(int r, int c);
    if (r == c) return "R6";
    if (r > c) return "R7";
    return phase;
  endfunction

  function automatic int sgn(logic b);
    return b ? 1 : -1;
  endfunction

  task automatic fail_line(string tag, int act, int expv);
    n_fail++;
    $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
  endtask

  // One clock: check last read, queue next expectation, drive, advance model
  task automatic cyc(input bit c_clr, input bit c_upd, input logic [VW-1:0] nb,
                     input logic [VW-1:0] ob, input bit req);
    int r, c;
    n_tests++;
    if (rd_valid !== exp_v) fail_line("R8 rd_valid", int'(rd_valid), int'(exp_v));
    if (exp_v) begin
      n_tests++;
      if (int'(rd_data) != exp_d) fail_line(exp_tag, int'(rd_data), exp_d);
    end
    r = (rd_ptr / VW) % VW;
    c = rd_ptr % VW;
    rd_ptr++;
    exp_v = req;
    exp_d = ref_read(r, c);
    exp_tag = tag_for(r, c);
    clr = c_clr; upd_valid = c_upd; new_bits = nb; old_bits = ob;
    rd_req = req; rd_row = 3'(r); rd_col = 3'(c);
    if (c_clr) begin
      for (int a = 0; a < VW; a++) for (int b = 0; b < VW; b++) refm[a][b] = 0;
      fills = 0;
    end else if (c_upd) begin
      for (int a = 0; a < VW; a++)
        for (int b = a + 1; b < VW; b++) begin
          int v;
          v = refm[a][b] + sgn(nb[a]) * sgn(nb[b]);
          if (fills >= L) v = v - sgn(ob[a]) * sgn(ob[b]);
          if (v > 127) v = 127;
          if (v < -128) v = -128;
          refm[a][b] = v;
        end
      if (fills < L) fills++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic win_update(input bit req);
    logic [VW-1:0] nb, ob;
    nb = rnd8();
    ob = (hist.size() == L) ? hist.pop_front() : rnd8();
    hist.push_back(nb);
    cyc(1'b0, 1'b1, nb, ob, req);
  endtask

  initial begin
    for (int a = 0; a < VW; a++) for (int b = 0; b < VW; b++) refm[a][b] = 0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (rd_valid !== 1'b0) fail_line("R1 reset rd_valid", int'(rd_valid), 0);
    n_tests++;
    if (rd_data !== 8'sd0) fail_line("R1 reset rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every entry reads zero after reset; R6 diagonal, R7 mirror
    phase = "R1";
    for (int i = 0; i < 64; i++) cyc(1'b0, 1'b0, '0, '0, 1'b1);

    // R4/R2: fill phase, outgoing vector is random garbage and must be ignored
    phase = "R4";
    rd_ptr = 1;
    for (int i = 0; i < L; i++) win_update(1'b1);
    for (int i = 0; i < 64; i++) cyc(1'b0, 1'b0, '0, '0, 1'b1);

    // R3: true sliding window
    phase = "R3";
    for (int i = 0; i < 120; i++) win_update(1'b1);

    // R9: inputs move but nothing is accepted
    phase = "R9";
    for (int i = 0; i < 70; i++) cyc(1'b0, 1'b0, rnd8(), rnd8(), 1'b1);

    // R5: drive toward the positive limit, then the negative limit
    phase = "R5";
    for (int i = 0; i < 90; i++) cyc(1'b0, 1'b1, 8'hFF, 8'h55, 1'b1);
    for (int i = 0; i < 64; i++) cyc(1'b0, 1'b0, '0, '0, 1'b1);
    for (int i = 0; i < 180; i++) cyc(1'b0, 1'b1, 8'h0F, 8'hFF, 1'b1);
    for (int i = 0; i < 64; i++) cyc(1'b0, 1'b0, '0, '0, 1'b1);

    // R1: clear and update together, clear wins
    phase = "R1";
    cyc(1'b1, 1'b1, 8'hFF, 8'h00, 1'b0);
    for (int i = 0; i < 64; i++) cyc(1'b0, 1'b0, '0, '0, 1'b1);

    // R2: single fill updates with a known pattern after clear
    phase = "R2";
    hist.delete();
    cyc(1'b0, 1'b1, 8'hA5, 8'h3C, 1'b1);
    for (int i = 0; i < 64; i++) cyc(1'b0, 1'b0, '0, '0, 1'b1);

    // R8: read requests interleaved with gaps and updates
    phase = "R8";
    for (int i = 0; i < 40; i++) cyc(1'b0, i[0], rnd8(), rnd8(), i[1]);
    cyc(1'b0, 1'b0, '0, '0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule